// File: doc/BRIEF.md
# Vectored Interrupt Request Controller

This block gathers interrupt requests from a small set of sources into a request register and picks one of them to service. Every source passes through a two-stage synchronizer and an edge detector. Two of the lines, numbered 0 and 2, can be set to fire on rising edges, falling edges or both. The polarity setting lives in the two bits above the request bits of that same register. The other lines fire on rising edges only.

A mask register and a global enable gate the pending requests. A rotating priority selector, set by a small priority register, picks the winner. When a request is granted, the sequencer does four things in order:

- clears the global enable;
- clears the winner's request bit;
- hands the core the program counter and flags it sampled, so the core can save them;
- reads a two-byte vector from program memory through a simple request/valid read port, then presents the 16-bit service address.

With every mask bit cleared, software can instead read the request register to find out which sources need service, and clear bits itself.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset, the request register (bits, edge select), mask, priority register and global enable are all zero, and no save, read or vector output is active.
- R2: A level change on a source input sets its request bit on the third rising clock edge after the change and not before.
- R3: The edge select field (register bits [NUM_SRC+1:NUM_SRC], bits 7:6 by default) sets how lines 0 and 2 trigger, written as line0/line2: 00 = falling/falling, 01 = rising/falling, 10 = falling/rising, 11 = both/both. All other lines trigger on rising edges only.
- R4: A write to the request register (address 0) clears every request bit written as zero and leaves bits written as one unchanged. A new edge on a line in the same cycle as that write sets its bit anyway.
- R5: A pending request whose mask bit (register address 1) is zero is never granted, and it stays visible in the request register.
- R6: For priority value p < NUM_SRC (register address 2), the order of precedence is p, p+1, and so on, wrapping past NUM_SRC-1 to 0. For p >= NUM_SRC the lowest-numbered source wins.
- R7: A grant happens only while the global enable is set and the sequencer is idle. The global enable is set by the input gie_set_i. A grant clears the global enable and the winner's request bit.
- R8: One cycle after a grant, save_valid_o is high for exactly one cycle and carries the pc_i and flags_i values sampled in the grant cycle.
- R9: For winning source n, the sequencer reads program address 2n and then 2n+1. It holds mem_rd_o and the address steady until mem_rvalid_i, and has only one read outstanding at a time.
- R10: After the second byte arrives, vec_valid_o is high for one cycle with vec_addr_o = {first byte, second byte} and vec_src_o = n. No further grant starts before then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_i | input | NUM_SRC | Raw request lines, asynchronous |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | 0 request/edge select, 1 mask, 2 priority |
| reg_wdata_i | input | NUM_SRC+2 | Register write data |
| req_reg_o | output | NUM_SRC+2 | Request register for polling: {edge select, request bits} |
| gie_set_i | input | 1 | Sets the global interrupt enable |
| gie_o | output | 1 | Global interrupt enable |
| pc_i | input | 2*DATA_W | Current program counter from the core |
| flags_i | input | DATA_W | Current status flags from the core |
| save_valid_o | output | 1 | Core should push save_pc_o / save_flags_o |
| save_pc_o | output | 2*DATA_W | Program counter to save |
| save_flags_o | output | DATA_W | Flags to save |
| mem_rd_o | output | 1 | Program memory read request |
| mem_addr_o | output | PM_AW | Program memory read address |
| mem_rdata_i | input | DATA_W | Read data |
| mem_rvalid_i | input | 1 | Read data valid |
| vec_valid_o | output | 1 | Service address ready |
| vec_addr_o | output | 2*DATA_W | Service routine start address |
| vec_src_o | output | $clog2(NUM_SRC) | Source that was granted |

## Verification
The bench uses the defaults: six sources, byte-wide data and a 12-bit program address. Six sources give two polarity-programmable lines next to four rising-only ones, so all four edge encodings can be checked against a fixed line in the same pass. A 3-bit priority register with six sources reaches both wrapping rotations and the two out-of-range values that fall back to lowest-index order. The program memory model returns a computed byte per address, so each vector proves both fetch addresses and the byte order.

// File: rtl/irq_pkg.sv
// Shared types for the interrupt controller.
// Assumes: register address map and edge-select encodings are fixed here.
package irq_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_SAVE,
        SQ_HI,
        SQ_LO,
        SQ_DONE
    } seq_state_t;

    typedef enum logic [1:0] {
        EDGE_RISE,
        EDGE_FALL,
        EDGE_BOTH
    } edge_kind_t;

    localparam logic [1:0] ADDR_REQ  = 2'd0;
    localparam logic [1:0] ADDR_MASK = 2'd1;
    localparam logic [1:0] ADDR_PRIO = 2'd2;

    // Maps the edge-select field to the trigger kind of one programmable line.
    function automatic edge_kind_t line_mode(input logic [1:0] sel, input logic second);
        edge_kind_t k;
        case (sel)
            2'b00:   k = EDGE_FALL;
            2'b01:   k = second ? EDGE_FALL : EDGE_RISE;
            2'b10:   k = second ? EDGE_RISE : EDGE_FALL;
            default: k = EDGE_BOTH;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/irq_edge_unit.sv
// Synchronizes every request line through two flops and detects edges.
// Lines LINE_A and LINE_B follow the programmable edge select; the rest
// detect rising edges only. hit_o is combinational from the flop chain.
// Assumes: source lines are low while reset is applied.
module irq_edge_unit
    import irq_pkg::*;
#(
    parameter int NUM_SRC = 6,
    parameter int LINE_A  = 0,
    parameter int LINE_B  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic [1:0]         edge_sel_i,
    output logic [NUM_SRC-1:0] hit_o
);

    logic [NUM_SRC-1:0] sync1_q, sync2_q, prev_q;

    // Two-flop synchronizer followed by a history flop for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1_q <= '0;
            sync2_q <= '0;
            prev_q  <= '0;
        end else begin
            sync1_q <= src_i;
            sync2_q <= sync1_q;
            prev_q  <= sync2_q;
        end
    end

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_line
        logic rise, fall;
        assign rise = sync2_q[g] & ~prev_q[g];
        assign fall = ~sync2_q[g] & prev_q[g];
        if (g == LINE_A || g == LINE_B) begin : g_prog
            edge_kind_t mode;
            assign mode     = line_mode(edge_sel_i, (g == LINE_B));
            assign hit_o[g] = (mode == EDGE_RISE) ? rise :
                              (mode == EDGE_FALL) ? fall : (rise | fall);
        end else begin : g_fixed
            assign hit_o[g] = rise;
        end
    end

endmodule

// File: rtl/irq_prio_pick.sv
// Picks one pending request. The priority value selects a rotation whose
// first source is that value; out-of-range values give lowest-index order.
// Purely combinational; the clock only samples the check.
module irq_prio_pick #(
    parameter int NUM_SRC = 6,
    parameter int IDX_W   = $clog2(NUM_SRC),
    parameter int PRIO_W  = IDX_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] pend_i,
    input  logic [PRIO_W-1:0]  prio_i,
    output logic               any_o,
    output logic [IDX_W-1:0]   win_o
);

    // Walks the rotation from the base source and stops at the first pending one.
    always_comb begin
        int base;
        int idx;
        logic found;
        base  = (int'(prio_i) < NUM_SRC) ? int'(prio_i) : 0;
        found = 1'b0;
        win_o = '0;
        for (int k = 0; k < NUM_SRC; k++) begin
            idx = base + k;
            if (idx >= NUM_SRC) idx = idx - NUM_SRC;
            if (!found && pend_i[idx]) begin
                found = 1'b1;
                win_o = IDX_W'(idx);
            end
        end
        any_o = found;
    end

    // R6
    win_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_o |-> pend_i[win_o]);

endmodule

// File: rtl/irq_vec_seq.sv
// Interrupt sequence: save pulse, two single-beat program reads (high byte
// at 2n, low byte at 2n+1), then a one-cycle vector output.
// Assumes: grant_i is raised only while idle_o is high.
module irq_vec_seq
    import irq_pkg::*;
#(
    parameter int NUM_SRC = 6,
    parameter int IDX_W   = $clog2(NUM_SRC),
    parameter int DATA_W  = 8,
    parameter int PM_AW   = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                grant_i,
    input  logic [IDX_W-1:0]    win_i,
    input  logic [2*DATA_W-1:0] pc_i,
    input  logic [DATA_W-1:0]   flags_i,
    output logic                idle_o,
    output logic                save_valid_o,
    output logic [2*DATA_W-1:0] save_pc_o,
    output logic [DATA_W-1:0]   save_flags_o,
    output logic                mem_rd_o,
    output logic [PM_AW-1:0]    mem_addr_o,
    input  logic [DATA_W-1:0]   mem_rdata_i,
    input  logic                mem_rvalid_i,
    output logic                vec_valid_o,
    output logic [2*DATA_W-1:0] vec_addr_o,
    output logic [IDX_W-1:0]    vec_src_o
);

    seq_state_t          state_q;
    logic [IDX_W-1:0]    src_q;
    logic [DATA_W-1:0]   hi_q, lo_q;
    logic [2*DATA_W-1:0] pc_q;
    logic [DATA_W-1:0]   fl_q;

    // State machine stepping through save, two fetches and completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            src_q   <= '0;
            hi_q    <= '0;
            lo_q    <= '0;
            pc_q    <= '0;
            fl_q    <= '0;
        end else begin
            case (state_q)
                SQ_IDLE: if (grant_i) begin
                    src_q   <= win_i;
                    pc_q    <= pc_i;
                    fl_q    <= flags_i;
                    state_q <= SQ_SAVE;
                end
                SQ_SAVE: state_q <= SQ_HI;
                SQ_HI: if (mem_rvalid_i) begin
                    hi_q    <= mem_rdata_i;
                    state_q <= SQ_LO;
                end
                SQ_LO: if (mem_rvalid_i) begin
                    lo_q    <= mem_rdata_i;
                    state_q <= SQ_DONE;
                end
                default: state_q <= SQ_IDLE;
            endcase
        end
    end

    // Output decode from the current state and captured data.
    always_comb begin
        idle_o       = (state_q == SQ_IDLE);
        save_valid_o = (state_q == SQ_SAVE);
        mem_rd_o     = (state_q == SQ_HI) || (state_q == SQ_LO);
        mem_addr_o   = (PM_AW'(src_q) << 1) | PM_AW'(state_q == SQ_LO);
        vec_valid_o  = (state_q == SQ_DONE);
    end

    assign save_pc_o    = pc_q;
    assign save_flags_o = fl_q;
    assign vec_addr_o   = {hi_q, lo_q};
    assign vec_src_o    = src_q;

    // R9
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_o && !mem_rvalid_i) |=> (mem_rd_o && $stable(mem_addr_o)));

    // R9
    save_then_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        save_valid_o |=> (mem_rd_o && !mem_addr_o[0]));

    // R10
    vec_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid_o |=> !vec_valid_o);

endmodule

// File: rtl/irq_vec_ctrl.sv
// Top: request register with edge select, mask, priority and global enable
// registers, edge detection, priority selection and the vector sequencer.
// Assumes: a register write and a grant may coincide; edges win over clears.
module irq_vec_ctrl
    import irq_pkg::*;
#(
    parameter int NUM_SRC = 6,
    parameter int DATA_W  = 8,
    parameter int PM_AW   = 12
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_SRC-1:0]         src_i,
    input  logic                       reg_wr_i,
    input  logic [1:0]                 reg_addr_i,
    input  logic [NUM_SRC+1:0]         reg_wdata_i,
    output logic [NUM_SRC+1:0]         req_reg_o,
    input  logic                       gie_set_i,
    output logic                       gie_o,
    input  logic [2*DATA_W-1:0]        pc_i,
    input  logic [DATA_W-1:0]          flags_i,
    output logic                       save_valid_o,
    output logic [2*DATA_W-1:0]        save_pc_o,
    output logic [DATA_W-1:0]          save_flags_o,
    output logic                       mem_rd_o,
    output logic [PM_AW-1:0]           mem_addr_o,
    input  logic [DATA_W-1:0]          mem_rdata_i,
    input  logic                       mem_rvalid_i,
    output logic                       vec_valid_o,
    output logic [2*DATA_W-1:0]        vec_addr_o,
    output logic [$clog2(NUM_SRC)-1:0] vec_src_o
);

    localparam int IDX_W = $clog2(NUM_SRC);

    logic [NUM_SRC-1:0] req_q, req_n, mask_q, hit;
    logic [1:0]         esel_q;
    logic [IDX_W-1:0]   prio_q, win;
    logic               gie_q, any_pend, seq_idle, grant;
    logic               wr_req;

    assign wr_req = reg_wr_i && (reg_addr_i == ADDR_REQ);
    assign grant  = seq_idle && gie_q && any_pend;

    irq_edge_unit #(.NUM_SRC(NUM_SRC), .LINE_A(0), .LINE_B(2)) u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_i      (src_i),
        .edge_sel_i (esel_q),
        .hit_o      (hit)
    );

    irq_prio_pick #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W), .PRIO_W(IDX_W)) u_pick (
        .clk    (clk),
        .rst_n  (rst_n),
        .pend_i (req_q & mask_q),
        .prio_i (prio_q),
        .any_o  (any_pend),
        .win_o  (win)
    );

    // Next request bits: software clear, grant clear, then new edges on top.
    always_comb begin
        req_n = req_q;
        if (wr_req) req_n = req_n & reg_wdata_i[NUM_SRC-1:0];
        if (grant)  req_n[win] = 1'b0;
        req_n = req_n | hit;
    end

    // Software-visible registers and the global enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q  <= '0;
            esel_q <= '0;
            mask_q <= '0;
            prio_q <= '0;
            gie_q  <= 1'b0;
        end else begin
            req_q <= req_n;
            if (wr_req) esel_q <= reg_wdata_i[NUM_SRC+1:NUM_SRC];
            if (reg_wr_i && reg_addr_i == ADDR_MASK) mask_q <= reg_wdata_i[NUM_SRC-1:0];
            if (reg_wr_i && reg_addr_i == ADDR_PRIO) prio_q <= reg_wdata_i[IDX_W-1:0];
            if (grant)          gie_q <= 1'b0;
            else if (gie_set_i) gie_q <= 1'b1;
        end
    end

    assign req_reg_o = {esel_q, req_q};
    assign gie_o     = gie_q;

    irq_vec_seq #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W), .DATA_W(DATA_W), .PM_AW(PM_AW)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .grant_i      (grant),
        .win_i        (win),
        .pc_i         (pc_i),
        .flags_i      (flags_i),
        .idle_o       (seq_idle),
        .save_valid_o (save_valid_o),
        .save_pc_o    (save_pc_o),
        .save_flags_o (save_flags_o),
        .mem_rd_o     (mem_rd_o),
        .mem_addr_o   (mem_addr_o),
        .mem_rdata_i  (mem_rdata_i),
        .mem_rvalid_i (mem_rvalid_i),
        .vec_valid_o  (vec_valid_o),
        .vec_addr_o   (vec_addr_o),
        .vec_src_o    (vec_src_o)
    );

    // R7
    grant_drops_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant |=> !gie_q);

    // R7
    grant_clears_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && !hit[win]) |=> !req_q[$past(win)]);

    // R10
    no_regrant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        save_valid_o |=> !save_valid_o);

endmodule

// File: tb/irq_vec_ctrl_tb.sv
// Directed bench: one task per scenario, each checking its own results.
module irq_vec_ctrl_tb;

    localparam int NUM_SRC = 6;
    localparam int DATA_W  = 8;
    localparam int PM_AW   = 12;

    logic               clk = 1'b0;
    logic               rst_n;
    logic [NUM_SRC-1:0] src;
    logic               reg_wr;
    logic [1:0]         reg_addr;
    logic [7:0]         reg_wdata;
    logic [7:0]         req_reg;
    logic               gie_set, gie;
    logic [15:0]        pc;
    logic [7:0]         flags;
    logic               save_valid;
    logic [15:0]        save_pc;
    logic [7:0]         save_flags;
    logic               mem_rd;
    logic [PM_AW-1:0]   mem_addr;
    logic [7:0]         mem_rdata;
    logic               mem_rvalid;
    logic               vec_valid;
    logic [15:0]        vec_addr;
    logic [2:0]         vec_src;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    irq_vec_ctrl #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .PM_AW(PM_AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .src_i(src), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
        .reg_wdata_i(reg_wdata), .req_reg_o(req_reg), .gie_set_i(gie_set), .gie_o(gie),
        .pc_i(pc), .flags_i(flags), .save_valid_o(save_valid), .save_pc_o(save_pc),
        .save_flags_o(save_flags), .mem_rd_o(mem_rd), .mem_addr_o(mem_addr),
        .mem_rdata_i(mem_rdata), .mem_rvalid_i(mem_rvalid), .vec_valid_o(vec_valid),
        .vec_addr_o(vec_addr), .vec_src_o(vec_src)
    );

    function automatic logic [7:0] pm_byte(input int a);
        return 8'((a * 29 + 53) & 255);
    endfunction

    // Program memory model: one-cycle response, one beat per request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_rvalid <= 1'b0;
            mem_rdata  <= '0;
        end else begin
            mem_rvalid <= mem_rd & ~mem_rvalid;
            mem_rdata  <= pm_byte(int'(mem_addr));
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic pulse_gie();
        @(negedge clk);
        gie_set = 1'b1;
        @(negedge clk);
        gie_set = 1'b0;
    endtask

    // Drop all sources, clear requests, then raise the given pattern.
    task automatic arm(input logic [5:0] pat);
        @(negedge clk);
        src = '0;
        cyc(4);
        wr(2'd0, 8'h00);
        src = pat;
        cyc(4);
    endtask

    task automatic wait_vec(output logic [2:0] s);
        s = 3'h7;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (vec_valid) begin
                s = vec_src;
                break;
            end
        end
    endtask

    task automatic t_reset();
        chk("R1 request register", 32'(req_reg), 32'h0);
        chk("R1 global enable", 32'(gie), 32'h0);
        chk("R1 outputs idle", {29'h0, save_valid, mem_rd, vec_valid}, 32'h0);
    endtask

    task automatic t_sync_latency();
        @(negedge clk);
        src[4] = 1'b1;
        cyc(2);
        chk("R2 not set after two edges", 32'(req_reg[4]), 32'h0);
        cyc(1);
        chk("R2 set after third edge", 32'(req_reg[4]), 32'h1);
    endtask

    task automatic t_edge_modes();
        for (int s = 0; s < 4; s++) begin
            logic [2:0] exp_r, exp_f;
            logic [1:0] sl;
            sl    = 2'(s);
            exp_r = {(sl == 2'b10 || sl == 2'b11), 1'b1, (sl == 2'b01 || sl == 2'b11)};
            exp_f = {(sl != 2'b10), 1'b0, (sl != 2'b01)};
            wr(2'd0, {sl, 6'h0});
            src[2:0] = 3'b111;
            cyc(4);
            chk($sformatf("R3 rising, sel %0d", s), 32'(req_reg[2:0]), 32'(exp_r));
            chk($sformatf("R3 select readback %0d", s), 32'(req_reg[7:6]), 32'(sl));
            wr(2'd0, {sl, 6'h0});
            src[2:0] = 3'b000;
            cyc(4);
            chk($sformatf("R3 falling, sel %0d", s), 32'(req_reg[2:0]), 32'(exp_f));
        end
    endtask

    task automatic t_sw_clear();
        arm(6'b001010);
        wr(2'd0, 8'b0000_1000);
        chk("R4 zero clears, one keeps", 32'(req_reg[5:0]), 32'h08);
        @(negedge clk);
        src[5] = 1'b1;
        cyc(2);
        reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 8'h00;
        @(negedge clk);
        reg_wr = 1'b0;
        chk("R4 edge wins over clear", 32'(req_reg[5:0]), 32'h20);
    endtask

    task automatic t_mask_poll();
        logic [2:0] s;
        int saves = 0;
        wr(2'd1, 8'h00);
        arm(6'b000010);
        pulse_gie();
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (save_valid) saves++;
        end
        chk("R5 masked not granted", 32'(saves), 32'h0);
        chk("R5 still pollable", 32'(req_reg[1]), 32'h1);
        chk("R7 enable kept without grant", 32'(gie), 32'h1);
        wr(2'd1, 8'h3F);
        wait_vec(s);
        chk("R5 granted once unmasked", 32'(s), 32'h1);
    endtask

    task automatic t_priority();
        logic [2:0] s;
        logic [2:0] pv[4]  = '{3'd3, 3'd7, 3'd4, 3'd6};
        logic [8:0] ord[4] = '{{3'd3, 3'd4, 3'd1}, {3'd1, 3'd3, 3'd4},
                               {3'd4, 3'd1, 3'd3}, {3'd1, 3'd3, 3'd4}};
        wr(2'd1, 8'h3F);
        for (int c = 0; c < 4; c++) begin
            wr(2'd2, {5'h0, pv[c]});
            arm(6'b011010);
            for (int k = 0; k < 3; k++) begin
                pulse_gie();
                wait_vec(s);
                chk($sformatf("R6 prio %0d pick %0d", pv[c], k), 32'(s),
                    32'(ord[c][8 - 3*k -: 3]));
            end
        end
        wr(2'd2, 8'h00);
    endtask

    task automatic t_grant_vector();
        int nsave = 0, nvec = 0, first_a = -1, last_a = -1;
        logic seen_rd = 1'b0;
        wr(2'd1, 8'h3F);
        pc = 16'hBEEF; flags = 8'h5A;
        arm(6'b010000);
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            gie_set = (i == 0) || (mem_rd && !seen_rd);
            if (i == 0) src[1] = 1'b1;
            if (save_valid) begin
                nsave++;
                if (nsave == 1) begin
                    chk("R8 saved pc", 32'(save_pc), 32'hBEEF);
                    chk("R8 saved flags", 32'(save_flags), 32'h5A);
                    chk("R7 enable cleared", 32'(gie), 32'h0);
                    chk("R7 winner bit cleared", 32'(req_reg[4]), 32'h0);
                end
            end
            if (mem_rd && nvec == 0) begin
                if (first_a < 0) first_a = int'(mem_addr);
                last_a = int'(mem_addr);
                seen_rd = 1'b1;
            end
            if (vec_valid) begin
                nvec++;
                if (nvec == 1) begin
                    chk("R9 first read address", 32'(first_a), 32'd8);
                    chk("R9 second read address", 32'(last_a), 32'd9);
                    chk("R10 vector value", 32'(vec_addr), {16'h0, pm_byte(8), pm_byte(9)});
                    chk("R10 vector source", 32'(vec_src), 32'h4);
                    chk("R10 no grant before done", 32'(nsave), 32'h1);
                end else if (nvec == 2) begin
                    chk("R10 next vector value", 32'(vec_addr), {16'h0, pm_byte(2), pm_byte(3)});
                    chk("R10 next vector source", 32'(vec_src), 32'h1);
                end
            end
        end
        gie_set = 1'b0;
        chk("R8 one save per grant", 32'(nsave), 32'h2);
        chk("R7 enable stays off", 32'(gie), 32'h0);
    endtask

    initial begin
        rst_n = 1'b0; src = '0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
        gie_set = 1'b0; pc = '0; flags = '0;
        cyc(3);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_sync_latency();
        t_edge_modes();
        t_sw_clear();
        t_mask_poll();
        t_priority();
        t_grant_vector();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule